// File: doc/BRIEF.md
# SDRAM Power-Up and Refresh Sequencer

This block owns the command pins of a single-rank SDR SDRAM from the moment reset is released. It first enables the memory clock and holds the bus idle through the power-up settling time. It then closes every bank and issues a counted train of auto-refresh commands. Next it programs the mode register with a burst length of one and a CAS latency of three. After that it reports that normal traffic may begin.

Once initialised, a free-running interval timer asks a host arbiter for a refresh slot. The reload value of that timer is the per-row refresh interval minus a fixed margin, which covers arbitration latency. The arbiter grants the slot by raising an acknowledge. The sequencer then precharges all banks, refreshes, and waits out the refresh cycle time while a busy flag is high. Every time constant is set at elaboration: a nanosecond parameter is turned into clock cycles as truncated (MHz × ns) / 1000, and the result is never less than one cycle. A downstream controller also receives the write-recovery time in cycles. That value is the largest of tRDL, tRAS − tRCD and tRC − tRCD − tRP.

There is no data stream here. All pins are plain control and status levels. The refresh request is a level that stays high until it is acknowledged, and an acknowledge given while no request is pending has no effect.

Top module: `sdrseq_top`

## Requirements
- R1: While `rst` is high, `cke` is 0, the command {cs_n, ras_n, cas_n, we_n} is NOP = 0111, `addr` and `ba` are 0, and `init_done`, `refresh_req` and `refresh_busy` are 0.
- R2: `cke` rises on the first clock edge after reset. Exactly PWR cycles of NOP with `cke` high then precede the first other command, where PWR = (CLK_MHZ × 200000) / 1000, which is 20000 at 100 MHz.
- R3: The first command after power-up is PRECHARGE ALL: pins 0010, `addr[10]` = 1, all other address bits 0.
- R4: Eight AUTO REFRESH commands (pins 0001) follow. The first comes tRP cycles after the precharge, and each later one tRFC cycles after the one before it (tRP = 1 and tRFC = 6 at 100 MHz). Only NOPs are issued in between.
- R5: LOAD MODE (pins 0000) follows tRFC cycles after the last refresh, with `ba` = 0 and `addr` = 0x030: burst-length code 0 in bits [2:0], CAS latency 3 in bits [6:4], all other bits 0.
- R6: `init_done` is 0 in the LOAD MODE cycle and rises tMRD = 1 cycle later. It never falls until reset.
- R7: `refresh_req` rises REF cycles after `init_done` rises, where REF = (CLK_MHZ × (64000000 / 8192)) / 1000 − 20, which is 761 at 100 MHz. Once high, it stays high until a cycle in which `refresh_ack` is sampled high.
- R8: When `refresh_ack` is sampled high while `refresh_req` is high, in the next cycle `refresh_busy` is 1 and `refresh_req` is 0. PRECHARGE ALL follows one cycle later and AUTO REFRESH tRP cycles after that. `refresh_busy` stays high for 1 + tRP + tRFC cycles in total (8 at 100 MHz).
- R9: A `refresh_ack` given while `refresh_req` is low is ignored: `refresh_busy` stays 0 and the pins stay NOP.
- R10: Successive rises of `refresh_req` are REF cycles apart, however long the arbiter takes to acknowledge.
- R11: `twr_cycles` equals max(tRDL, tRAS − tRCD, tRC − tRCD − tRP) in cycles, which is 4 at 100 MHz.
- R12: After initialisation, with no grant pending, only NOP is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, same as the SDRAM clock |
| rst | input | 1 | Synchronous active-high reset |
| refresh_ack | input | 1 | Arbiter grant of a refresh slot |
| cke | output | 1 | SDRAM clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W (2) | Bank address |
| addr | output | ADDR_W (12) | Address bus; A10 selects all banks on precharge |
| init_done | output | 1 | Power-up sequence complete |
| refresh_req | output | 1 | Refresh slot wanted |
| refresh_busy | output | 1 | Refresh in progress |
| twr_cycles | output | TWR_W (8) | Derived write-recovery time in cycles |

## Verification
The assertions check the rules that hold on every cycle. `init_done` never falls, `refresh_busy` only appears after initialisation, a pending request persists until it is granted, and an ungranted request never starts a refresh. They also check that every precharge carries A10, that LOAD MODE uses bank 0 and only occurs before `init_done`, and that the wait counter steps down by one. The exact cycle distances need the bench's scenarios to show them: the power-up hold, the tRP and tRFC spacing of the refresh train, the mode-register value, the refresh interval and its independence from grant latency.

// File: rtl/sdrseq_pkg.sv
package sdrseq_pkg;

  // Command codes on {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    C_LMR  = 4'b0000,
    C_AREF = 4'b0001,
    C_PRE  = 4'b0010,
    C_NOP  = 4'b0111
  } sdr_cmd_e;

  typedef enum logic [2:0] {
    S_PWR  = 3'd0,  // power-up hold, then precharge all
    S_IREF = 3'd1,  // initial refresh train
    S_ILMR = 3'd2,  // mode register load
    S_IFIN = 3'd3,  // tMRD wait, then init_done
    S_IDLE = 3'd4,  // normal operation
    S_RPRE = 3'd5,  // granted refresh: precharge
    S_RREF = 3'd6,  // granted refresh: auto refresh
    S_RWT  = 3'd7   // granted refresh: tRFC wait
  } seq_state_e;

  // Truncating conversion of nanoseconds to clock cycles
  function automatic int cyc_of_ns(input int mhz, input int ns);
    return (mhz * ns) / 1000;
  endfunction

  function automatic int at_least_one(input int v);
    return (v < 1) ? 1 : v;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/sdrseq_delay.sv
module sdrseq_delay #(
  parameter int CNT_W   = 16,
  parameter int RST_VAL = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= CNT_W'(RST_VAL);
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

  // R4
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && !zero) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/sdrseq_refi.sv
module sdrseq_refi #(
  parameter int PERIOD = 761,
  parameter int W      = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run)        cnt_q <= W'(PERIOD - 1);
    else if (cnt_q == '0)   cnt_q <= W'(PERIOD - 1);
    else                    cnt_q <= cnt_q - 1'b1;
  end

  assign tick = run && (cnt_q == '0);

  generate
    if (PERIOD > 1) begin : g_spacing
      // R10
      tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
    end
  endgenerate

endmodule

// File: rtl/sdrseq_pins.sv
module sdrseq_pins
  import sdrseq_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int BA_W   = 2,
  parameter int AP_BIT = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  sdr_cmd_e          cmd_in,
  input  logic [ADDR_W-1:0] addr_in,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cke                      <= 1'b0;
      {cs_n, ras_n, cas_n, we_n} <= C_NOP;
      addr                     <= '0;
      ba                       <= '0;
    end else begin
      cke                      <= 1'b1;
      {cs_n, ras_n, cas_n, we_n} <= cmd_in;
      addr                     <= addr_in;
      ba                       <= '0;
    end
  end

  // R3
  pre_all_chk: assert property (@(posedge clk) disable iff (rst)
    ({cs_n, ras_n, cas_n, we_n} == C_PRE) |-> addr[AP_BIT]);

  // R5
  lmr_bank_chk: assert property (@(posedge clk) disable iff (rst)
    ({cs_n, ras_n, cas_n, we_n} == C_LMR) |-> (ba == '0));

endmodule

// File: rtl/sdrseq_top.sv
module sdrseq_top
  import sdrseq_pkg::*;
#(
  parameter int CLK_MHZ      = 100,
  parameter int ADDR_W       = 12,
  parameter int BA_W         = 2,
  parameter int TWR_W        = 8,
  parameter int POWERUP_NS   = 200000,
  parameter int TRP_NS       = 18,
  parameter int TRFC_NS      = 60,
  parameter int TRCD_NS      = 18,
  parameter int TRAS_NS      = 42,
  parameter int TRC_NS       = 60,
  parameter int TRDL_NS      = 12,
  parameter int TMRD_CYC     = 1,
  parameter int INIT_REFS    = 8,
  parameter int RETENTION_NS = 64000000,
  parameter int ROWS         = 8192,
  parameter int REF_MARGIN   = 20,
  parameter int CAS_LAT      = 3,
  parameter int BL_CODE      = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              refresh_ack,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic              init_done,
  output logic              refresh_req,
  output logic              refresh_busy,
  output logic [TWR_W-1:0]  twr_cycles
);

  localparam int AP_BIT   = 10;
  localparam int PWR_CYC  = at_least_one(cyc_of_ns(CLK_MHZ, POWERUP_NS));
  localparam int TRP_CYC  = at_least_one(cyc_of_ns(CLK_MHZ, TRP_NS));
  localparam int TRFC_CYC = at_least_one(cyc_of_ns(CLK_MHZ, TRFC_NS));
  localparam int TRCD_CYC = at_least_one(cyc_of_ns(CLK_MHZ, TRCD_NS));
  localparam int TRAS_CYC = at_least_one(cyc_of_ns(CLK_MHZ, TRAS_NS));
  localparam int TRC_CYC  = at_least_one(cyc_of_ns(CLK_MHZ, TRC_NS));
  localparam int TRDL_CYC = at_least_one(cyc_of_ns(CLK_MHZ, TRDL_NS));
  localparam int TMRD_C   = at_least_one(TMRD_CYC);
  localparam int TWR_CYC  = at_least_one(max3(TRDL_CYC, TRAS_CYC - TRCD_CYC,
                                              TRC_CYC - TRCD_CYC - TRP_CYC));
  localparam int REF_CYC  = at_least_one(cyc_of_ns(CLK_MHZ, RETENTION_NS / ROWS) - REF_MARGIN);
  localparam int DLY_MAX  = max3(PWR_CYC, TRFC_CYC, max3(TRP_CYC, TMRD_C, 1));
  localparam int DLY_W    = $clog2(DLY_MAX + 1);
  localparam int REF_W    = $clog2(REF_CYC + 1);
  localparam int RC_W     = (INIT_REFS > 2) ? $clog2(INIT_REFS) : 1;

  localparam logic [ADDR_W-1:0] PRE_ADDR = ADDR_W'(1 << AP_BIT);
  localparam logic [ADDR_W-1:0] MODE_VAL = ADDR_W'(((CAS_LAT % 8) << 4) | (BL_CODE % 8));

  seq_state_e        st_q, st_nx;
  sdr_cmd_e          cmd_nx;
  logic [ADDR_W-1:0] addr_nx;
  logic              dly_load, dly_zero;
  logic [DLY_W-1:0]  dly_val;
  logic [RC_W-1:0]   rc_q;
  logic              rc_inc, done_set, accept, busy_clr, tick;
  logic              done_q, req_q, busy_q;

  // Shared inter-command wait counter; reset value covers the power-up hold
  sdrseq_delay #(.CNT_W(DLY_W), .RST_VAL(PWR_CYC)) u_dly (
    .clk      (clk),
    .rst      (rst),
    .load     (dly_load),
    .load_val (dly_val),
    .zero     (dly_zero)
  );

  // Free-running refresh interval timer, started by init completion
  sdrseq_refi #(.PERIOD(REF_CYC), .W(REF_W)) u_refi (
    .clk  (clk),
    .rst  (rst),
    .run  (done_q),
    .tick (tick)
  );

  sdrseq_pins #(.ADDR_W(ADDR_W), .BA_W(BA_W), .AP_BIT(AP_BIT)) u_pins (
    .clk     (clk),
    .rst     (rst),
    .cmd_in  (cmd_nx),
    .addr_in (addr_nx),
    .cke     (cke),
    .cs_n    (cs_n),
    .ras_n   (ras_n),
    .cas_n   (cas_n),
    .we_n    (we_n),
    .ba      (ba),
    .addr    (addr)
  );

  // A command is issued only when the wait counter has drained
  always_comb begin
    st_nx    = st_q;
    cmd_nx   = C_NOP;
    addr_nx  = '0;
    dly_load = 1'b0;
    dly_val  = '0;
    rc_inc   = 1'b0;
    done_set = 1'b0;
    accept   = 1'b0;
    busy_clr = 1'b0;
    unique case (st_q)
      S_PWR: if (dly_zero) begin
        cmd_nx   = C_PRE;
        addr_nx  = PRE_ADDR;
        dly_load = 1'b1;
        dly_val  = DLY_W'(TRP_CYC - 1);
        st_nx    = S_IREF;
      end
      S_IREF: if (dly_zero) begin
        cmd_nx   = C_AREF;
        dly_load = 1'b1;
        dly_val  = DLY_W'(TRFC_CYC - 1);
        rc_inc   = 1'b1;
        if (rc_q == RC_W'(INIT_REFS - 1)) st_nx = S_ILMR;
      end
      S_ILMR: if (dly_zero) begin
        cmd_nx   = C_LMR;
        addr_nx  = MODE_VAL;
        dly_load = 1'b1;
        dly_val  = DLY_W'(TMRD_C - 1);
        st_nx    = S_IFIN;
      end
      S_IFIN: if (dly_zero) begin
        done_set = 1'b1;
        st_nx    = S_IDLE;
      end
      S_IDLE: if (req_q && refresh_ack) begin
        accept = 1'b1;
        st_nx  = S_RPRE;
      end
      S_RPRE: if (dly_zero) begin
        cmd_nx   = C_PRE;
        addr_nx  = PRE_ADDR;
        dly_load = 1'b1;
        dly_val  = DLY_W'(TRP_CYC - 1);
        st_nx    = S_RREF;
      end
      S_RREF: if (dly_zero) begin
        cmd_nx   = C_AREF;
        dly_load = 1'b1;
        dly_val  = DLY_W'(TRFC_CYC - 1);
        st_nx    = S_RWT;
      end
      S_RWT: if (dly_zero) begin
        busy_clr = 1'b1;
        st_nx    = S_IDLE;
      end
      default: st_nx = S_PWR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= S_PWR;
      rc_q   <= '0;
      done_q <= 1'b0;
      req_q  <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      st_q   <= st_nx;
      if (rc_inc) rc_q <= rc_q + 1'b1;
      done_q <= done_q | done_set;
      req_q  <= tick | (req_q & ~accept);
      busy_q <= accept | (busy_q & ~busy_clr);
    end
  end

  assign init_done    = done_q;
  assign refresh_req  = req_q;
  assign refresh_busy = busy_q;
  assign twr_cycles   = TWR_W'(TWR_CYC);

  // R6
  done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done);

  // R8
  busy_after_init_chk: assert property (@(posedge clk) disable iff (rst)
    refresh_busy |-> init_done);

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (refresh_req && !refresh_ack) |=> refresh_req);

  // R9
  ack_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (!refresh_req && !refresh_busy) |=> !refresh_busy);

  // R5
  lmr_before_done_chk: assert property (@(posedge clk) disable iff (rst)
    ({cs_n, ras_n, cas_n, we_n} == C_LMR) |-> !init_done);

endmodule

// File: tb/sim_sdrseq_top.sv
module sim_sdrseq_top;

  localparam int PWR   = 20000;
  localparam int TRP   = 1;
  localparam int TRFC  = 6;
  localparam int REF   = 761;
  localparam int BUSYN = 1 + TRP + TRFC;
  localparam logic [11:0] PRE_A  = 12'h400;
  localparam logic [11:0] MODE_A = 12'h030;
  localparam logic [3:0] NOP = 4'b0111, PRE = 4'b0010, AREF = 4'b0001, LMR = 4'b0000;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst, ack;
  logic        cke, cs_n, ras_n, cas_n, we_n, init_done, refresh_req, refresh_busy;
  logic [1:0]  ba;
  logic [11:0] addr;
  logic [7:0]  twr_cycles;

  int n_run = 0, n_fail = 0;
  longint cyc = 0;
  longint t_req = 0;

  sdrseq_top u0 (
    .clk(clk), .rst(rst), .refresh_ack(ack),
    .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .addr(addr), .init_done(init_done), .refresh_req(refresh_req),
    .refresh_busy(refresh_busy), .twr_cycles(twr_cycles)
  );

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [3:0] pins();
    return {cs_n, ras_n, cas_n, we_n};
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1; ack = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 cke", cke, 0);
    chk("R1 cmd", pins(), NOP);
    chk("R1 addr", addr, 0);
    chk("R1 ba", ba, 0);
    chk("R1 flags", {init_done, refresh_req, refresh_busy}, 0);
    chk("R11 twr", twr_cycles, 4);
  endtask

  task automatic t_powerup();
    int n = 0, bad = 0;
    rst = 1'b0;
    for (int i = 0; i < PWR + 100; i++) begin
      @(negedge clk);
      if (pins() != NOP) break;
      n++;
      if (!cke) bad++;
    end
    chk("R2 nop hold", n, PWR);
    chk("R2 cke high", bad, 0);
    chk("R3 precharge cmd", pins(), PRE);
    chk("R3 precharge addr", addr, PRE_A);
  endtask

  task automatic gap_to_cmd(output int g);
    g = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      g++;
      if (pins() != NOP) break;
    end
  endtask

  task automatic t_init_train();
    int g;
    for (int i = 0; i < 8; i++) begin
      gap_to_cmd(g);
      chk("R4 refresh spacing", g, (i == 0) ? TRP : TRFC);
      chk("R4 refresh cmd", pins(), AREF);
    end
    gap_to_cmd(g);
    chk("R5 mode spacing", g, TRFC);
    chk("R5 mode cmd", pins(), LMR);
    chk("R5 mode value", addr, MODE_A);
    chk("R5 mode bank", ba, 0);
    chk("R6 done low at mode load", init_done, 0);
    @(negedge clk);
    chk("R6 done after tMRD", init_done, 1);
  endtask

  task automatic t_timer();
    int k = 0, nonnop = 0;
    for (int i = 0; i < REF + 50; i++) begin
      @(negedge clk);
      k++;
      if (pins() != NOP) nonnop++;
      if (k == 100) begin
        ack = 1'b1;
        @(negedge clk);
        k++;
        ack = 1'b0;
        chk("R9 ack without req busy", refresh_busy, 0);
        chk("R9 ack without req cmd", pins(), NOP);
      end
      if (refresh_req) break;
    end
    t_req = cyc;
    chk("R7 first request delay", k, REF);
    chk("R12 idle commands", nonnop, 0);
    chk("R6 done sticky", init_done, 1);
  endtask

  task automatic t_grant();
    int b = 3, nonnop = 0;
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    chk("R8 busy on grant", refresh_busy, 1);
    chk("R8 req cleared", refresh_req, 0);
    chk("R8 nop on grant", pins(), NOP);
    @(negedge clk);
    chk("R8 precharge", pins(), PRE);
    chk("R8 precharge addr", addr, PRE_A);
    repeat (TRP) @(negedge clk);
    chk("R8 refresh", pins(), AREF);
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (!refresh_busy) break;
      b++;
      if (pins() != NOP) nonnop++;
    end
    chk("R8 busy length", b, BUSYN);
    chk("R8 nop during tRFC", nonnop, 0);
  endtask

  task automatic wait_req_rise(output longint t);
    t = 0;
    for (int i = 0; i < REF + 50; i++) begin
      @(negedge clk);
      if (refresh_req) begin t = cyc; break; end
    end
  endtask

  task automatic t_period();
    longint t;
    int low = 0;
    wait_req_rise(t);
    chk("R10 period prompt grant", t - t_req, REF);
    t_req = t;
    repeat (50) begin
      @(negedge clk);
      if (!refresh_req) low++;
    end
    chk("R7 req held until ack", low, 0);
    t_grant();
    wait_req_rise(t);
    chk("R10 period late grant", t - t_req, REF);
  endtask

  initial begin
    #(4 * 60000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_powerup();
    t_init_train();
    t_timer();
    t_grant();
    t_period();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule